// File: doc/BRIEF.md
# PC-Relative Branch Resolver

This block takes one 16-bit instruction halfword per cycle, together with the byte address at which that instruction sits and a small vector of comparison flags left by an earlier compare. When the top two bits of the halfword are both one, the halfword belongs to the short branch format. In that format, bits [13:10] select one of sixteen opcode slots and bits [9:0] carry a signed displacement counted in halfwords. The block decides whether the branch is taken, forms the byte target address, and flags the opcode slots that have no branch meaning.

The displacement is sign-extended, shifted left by one and added to the instruction's own address. This gives a reach of roughly one kilobyte in either direction. For example, a displacement of 4 halfwords (+8 bytes) from a 2-byte branch lands just past a following 6-byte instruction. All results are captured in one register stage. A valid strobe on the input produces a valid strobe on the output one clock later. A fetch unit can consume the taken bit and the target to redirect.

Top module: `br_resolve`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, out_vld, taken and bad_op are 0 and target is all zeros.
- R2: out_vld is 1 in exactly those cycles that follow a rising clock edge at which in_vld was 1, and is 0 otherwise.
- R3: An input with instr[15:14] other than 2'b11 is not a branch. Its result has taken = 0 and bad_op = 0 while out_vld is 1.
- R4: For every accepted input, target equals pc plus instr[9:0] sign-extended (bit 9 is the sign) and multiplied by two, modulo 2^ADDR_W.
- R5: For a branch-format input with opcode instr[13:10] in 0..8, taken follows the flag vector cc, where bit 0 = equal, bit 1 = signed less, bit 2 = signed greater, bit 3 = unsigned less and bit 4 = unsigned greater. The opcodes map as follows: 0 equal; 1 not equal; 2 signed less; 3 signed greater; 4 unsigned less; 5 unsigned greater; 6 signed greater or equal; 7 signed less or equal; 8 unsigned greater or equal. Opcodes 6 to 8 each mean "greater (or less) flag OR equal flag". bad_op is 0 for these opcodes.
- R6: For a branch-format input with opcode 9..15, bad_op is 1 and taken is 0, whatever the flags.
- R7: taken and bad_op are never 1 together, and neither is 1 while out_vld is 0.
- R8: In a cycle that follows an edge with in_vld = 0, target keeps the value it had.
- R9: Displacement extremes: instr[9:0] = 10'h1FF gives pc + 1022, 10'h200 gives pc − 1024, and 10'h3FF gives pc − 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input halfword, address and flags are valid this cycle |
| instr | input | 16 | Instruction halfword |
| pc | input | ADDR_W (32) | Byte address of the instruction |
| cc | input | 5 | Compare flags: eq, signed lt, signed gt, unsigned lt, unsigned gt (bits 0..4) |
| out_vld | output | 1 | Result registers hold a fresh result |
| taken | output | 1 | Branch condition holds |
| target | output | ADDR_W (32) | Resolved byte target address |
| bad_op | output | 1 | Branch-format opcode with no assigned condition |

## Verification
Several properties are checked on every cycle by the assertions:
- the one-cycle valid relation;
- the exclusivity of taken and bad_op and their gating by out_vld;
- the quiet result for halfwords outside the branch format;
- the forced not-taken on unused opcodes;
- the target arithmetic against the registered-past inputs;
- the holding of target across idle cycles.

The mapping of each of the nine conditions onto the flag vector is shown only by the bench's exhaustive sweep. That sweep covers all sixteen opcodes against all thirty-two flag patterns. The same holds for the displacement extremes and address wrap-around, which the sweep reaches through chosen immediates and addresses near the top of the address space.

// File: rtl/br_pkg.sv
// Package: shared encodings for the short branch format.
// Assumes a 16-bit halfword with a 2-bit format prefix, a 4-bit opcode
// and a 10-bit halfword displacement.
package br_pkg;
    localparam int INSTR_W = 16;
    localparam int OP_W    = 4;
    localparam int DISP_W  = 10;
    localparam int CC_W    = 5;

    // Position of each flag in the compare vector.
    localparam int CC_EQ  = 0;
    localparam int CC_LTS = 1;
    localparam int CC_GTS = 2;
    localparam int CC_LTU = 3;
    localparam int CC_GTU = 4;

    localparam logic [1:0] FMT_BRANCH = 2'b11;

    typedef enum logic [OP_W-1:0] {
        OP_EQ  = 4'd0,
        OP_NE  = 4'd1,
        OP_LT  = 4'd2,
        OP_GT  = 4'd3,
        OP_LTU = 4'd4,
        OP_GTU = 4'd5,
        OP_GE  = 4'd6,
        OP_LE  = 4'd7,
        OP_GEU = 4'd8
    } br_op_e;

    localparam logic [OP_W-1:0] OP_LAST = 4'd8;
endpackage

// File: rtl/br_decode.sv
// Module: br_decode
// Splits a halfword into format match, opcode and displacement.
// Assumes the branch format is marked by FMT_BRANCH in bits [15:14].
module br_decode
    import br_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               is_branch,
    output logic [OP_W-1:0]    opcode,
    output logic [DISP_W-1:0]  disp
);
    // Field extraction and format match.
    always_comb begin
        is_branch = (instr[INSTR_W-1 -: 2] == FMT_BRANCH);
        opcode    = instr[DISP_W +: OP_W];
        disp      = instr[DISP_W-1:0];
    end
endmodule

// File: rtl/br_cond.sv
// Module: br_cond
// Evaluates a branch opcode against the compare flag vector.
// Assumes the flags came from a single earlier compare; opcodes past
// OP_LAST report known = 0 and hit = 0.
module br_cond
    import br_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic [CC_W-1:0] cc,
    output logic            known,
    output logic            hit
);
    logic eq, lts, gts, ltu, gtu;

    // Unpack the flag vector into named terms.
    always_comb begin
        eq  = cc[CC_EQ];
        lts = cc[CC_LTS];
        gts = cc[CC_GTS];
        ltu = cc[CC_LTU];
        gtu = cc[CC_GTU];
    end

    // Condition select by opcode.
    always_comb begin
        known = 1'b1;
        case (opcode)
            OP_EQ:   hit = eq;
            OP_NE:   hit = !eq;
            OP_LT:   hit = lts;
            OP_GT:   hit = gts;
            OP_LTU:  hit = ltu;
            OP_GTU:  hit = gtu;
            OP_GE:   hit = gts | eq;
            OP_LE:   hit = lts | eq;
            OP_GEU:  hit = gtu | eq;
            default: begin
                hit   = 1'b0;
                known = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/br_target.sv
// Module: br_target
// Forms pc + (sign-extended displacement << 1).
// Assumes ADDR_W > DISP_W + 1; the sum wraps modulo 2^ADDR_W.
module br_target
    import br_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] dest
);
    localparam int EXT_W = ADDR_W - DISP_W - 1;

    logic [ADDR_W-1:0] offset;

    // Sign-extend and scale the halfword count to bytes.
    always_comb offset = {{EXT_W{disp[DISP_W-1]}}, disp, 1'b0};

    // Add the byte offset to the instruction address.
    always_comb dest = pc + offset;
endmodule

// File: rtl/br_resolve.sv
// Module: br_resolve (top)
// One registered stage that decodes a short branch halfword and reports
// taken, target and unused-opcode status a cycle after in_vld.
// Assumes synchronous active-low reset; target holds when idle.
module br_resolve
    import br_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [ADDR_W-1:0]   pc,
    input  logic [CC_W-1:0]     cc,
    output logic                out_vld,
    output logic                taken,
    output logic [ADDR_W-1:0]   target,
    output logic                bad_op
);
    logic              is_branch;
    logic [OP_W-1:0]   opcode;
    logic [DISP_W-1:0] disp;
    logic              known;
    logic              hit;
    logic [ADDR_W-1:0] dest;

    br_decode u_dec (
        .instr     (instr),
        .is_branch (is_branch),
        .opcode    (opcode),
        .disp      (disp)
    );

    br_cond u_cond (
        .opcode (opcode),
        .cc     (cc),
        .known  (known),
        .hit    (hit)
    );

    br_target #(.ADDR_W(ADDR_W)) u_tgt (
        .pc   (pc),
        .disp (disp),
        .dest (dest)
    );

    // Valid strobe and qualified status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            taken   <= 1'b0;
            bad_op  <= 1'b0;
        end else begin
            out_vld <= in_vld;
            taken   <= in_vld & is_branch & known & hit;
            bad_op  <= in_vld & is_branch & !known;
        end
    end

    // Target capture only on accepted inputs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            target <= '0;
        else if (in_vld)
            target <= dest;
    end
endmodule

// File: rtl/br_resolve_chk.sv
// Module: br_resolve_chk
// Cycle-level properties of br_resolve, attached by bind.
module br_resolve_chk
    import br_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_vld,
    input logic [INSTR_W-1:0] instr,
    input logic [ADDR_W-1:0]  pc,
    input logic [CC_W-1:0]    cc,
    input logic               out_vld,
    input logic               taken,
    input logic [ADDR_W-1:0]  target,
    input logic               bad_op
);
    localparam int EXT_W = ADDR_W - DISP_W - 1;

    p_vld_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    p_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    p_not_branch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && instr[15:14] != 2'b11) |=> (!taken && !bad_op));
    p_target_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> target == $past(pc)
            + {{EXT_W{$past(instr[9])}}, $past(instr[9:0]), 1'b0});
    p_unused_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && instr[15:14] == 2'b11 && instr[13:10] > 4'd8)
            |=> (bad_op && !taken));
    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(taken && bad_op));
    p_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (taken || bad_op) |-> out_vld);
    p_hold_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> $stable(target));
endmodule

bind br_resolve br_resolve_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_br_resolve.sv
module sim_br_resolve;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [15:0]   instr = '0;
    logic [AW-1:0] pc = '0;
    logic [4:0]    cc = '0;
    logic          out_vld, taken, bad_op;
    logic [AW-1:0] target;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Expected result of the input currently in flight.
    logic          e_taken, e_bad;
    logic [AW-1:0] e_tgt;

    br_resolve #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .instr(instr), .pc(pc),
        .cc(cc), .out_vld(out_vld), .taken(taken), .target(target),
        .bad_op(bad_op)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic cond_of(input logic [3:0] op, input logic [4:0] f);
        case (op)
            4'd0: return f[0];
            4'd1: return !f[0];
            4'd2: return f[1];
            4'd3: return f[2];
            4'd4: return f[3];
            4'd5: return f[4];
            4'd6: return f[2] | f[0];
            4'd7: return f[1] | f[0];
            4'd8: return f[4] | f[0];
            default: return 1'b0;
        endcase
    endfunction

    // Drive one input at a falling edge and check its result one edge later.
    task automatic send(input logic [15:0] ins, input logic [AW-1:0] a,
                        input logic [4:0] f, input string req);
        logic signed [AW-1:0] d;
        instr  = ins;
        pc     = a;
        cc     = f;
        in_vld = 1'b1;
        d      = AW'(signed'(ins[9:0])) * 2;
        e_tgt  = a + d;
        e_taken = (ins[15:14] == 2'b11) && cond_of(ins[13:10], f);
        e_bad   = (ins[15:14] == 2'b11) && (ins[13:10] > 4'd8);
        @(negedge clk);
        chk(out_vld === 1'b1, "R2", 64'(out_vld), 64'd1);
        chk(taken === e_taken, req, 64'(taken), 64'(e_taken));
        chk(bad_op === e_bad, "R6", 64'(bad_op), 64'(e_bad));
        chk(target === e_tgt, "R4", 64'(target), 64'(e_tgt));
        chk(!(taken && bad_op), "R7", 64'({taken, bad_op}), 64'd0);
    endtask

    // One idle cycle: result strobe drops, target holds.
    task automatic idle();
        logic [AW-1:0] held;
        held   = target;
        in_vld = 1'b0;
        pc     = ~pc;
        instr  = ~instr;
        @(negedge clk);
        chk(out_vld === 1'b0, "R2", 64'(out_vld), 64'd0);
        chk(taken === 1'b0 && bad_op === 1'b0, "R7", 64'({taken, bad_op}), 64'd0);
        chk(target === held, "R8", 64'(target), 64'(held));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin : stim
        logic [9:0]    imms [6];
        logic [AW-1:0] pcs  [3];
        imms = '{10'h000, 10'h001, 10'h1FF, 10'h200, 10'h3FF, 10'h155};
        pcs  = '{32'h0000_1000, 32'hFFFF_FFFE, 32'h0000_0002};

        // R1: state during reset, with inputs active.
        in_vld = 1'b1;
        instr  = 16'hC000;
        cc     = 5'h1F;
        pc     = 32'h1234_5678;
        repeat (3) @(negedge clk);
        chk(out_vld === 1'b0 && taken === 1'b0 && bad_op === 1'b0, "R1",
            64'({out_vld, taken, bad_op}), 64'd0);
        chk(target === '0, "R1", 64'(target), 64'd0);
        in_vld = 1'b0;
        rst_n  = 1'b1;
        @(negedge clk);
        chk(out_vld === 1'b0 && target === '0, "R1", 64'(target), 64'd0);

        // R5/R6: all opcodes against all flag patterns, several displacements.
        for (int p = 0; p < 3; p++)
            for (int k = 0; k < 6; k++)
                for (int op = 0; op < 16; op++) begin
                    for (int f = 0; f < 32; f++)
                        send({2'b11, 4'(op), imms[k]}, pcs[p], 5'(f), "R5");
                    idle();
                end

        // R3: other format prefixes never branch.
        for (int pre = 0; pre < 3; pre++)
            for (int op = 0; op < 16; op++)
                for (int f = 0; f < 32; f += 7)
                    send({2'(pre), 4'(op), 10'h2A5}, 32'h0000_8000, 5'(f), "R3");
        idle();

        // R9: displacement extremes, eq branch with eq flag set.
        send(16'hC1FF, 32'h0000_4000, 5'b00001, "R9");
        chk(target === 32'h0000_43FE, "R9", 64'(target), 64'h43FE);
        send(16'hC200, 32'h0000_4000, 5'b00001, "R9");
        chk(target === 32'h0000_3C00, "R9", 64'(target), 64'h3C00);
        send(16'hC3FF, 32'h0000_4000, 5'b00001, "R9");
        chk(target === 32'h0000_3FFE, "R9", 64'(target), 64'h3FFE);
        // +8 bytes: displacement of four halfwords.
        send(16'hC004, 32'h0000_0100, 5'b00001, "R9");
        chk(target === 32'h0000_0108, "R9", 64'(target), 64'h108);
        idle();
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule